// File: doc/BRIEF.md
# Timer Tick Scheduling Assist

This block takes over the work a kernel clock interrupt handler does on every periodic timer tick. When a tick strobe arrives it sends an end-of-interrupt acknowledge to the interrupt controller. It then updates the system's time counters and the two scheduling countdowns. The time counters are a free-running millisecond count and a seconds count. The seconds count is kept by a reloading sub-counter. The scheduling countdowns are the delay of the head entry of a delta-ordered sleep queue and the remaining preemption quantum.

Each countdown reports expiry with its own one-cycle request pulse. Expiry of the sleep-head delay gives a wakeup request. Expiry of the quantum gives a reschedule request. Each request also sets a sticky status bit, which software clears with a clear strobe. Software keeps the queue storage and does the task switch itself. It reloads the head delay or the quantum through load ports after it has served a request.

Processing is a three-state sequence:
- **IDLE** waits for a tick.
- **ACK** emits the acknowledge and commits all counter updates at its closing edge.
- **NOTIFY** presents the request pulses and then returns to IDLE.

The transitions are:
- IDLE→ACK when a tick is sampled.
- ACK→NOTIFY unconditionally.
- NOTIFY→IDLE unconditionally.

Top module: `tick_assist`

## Requirements
- R1: Each accepted tick adds one to the 32-bit millisecond count. The new value is visible two cycles after the cycle in which the tick is sampled in IDLE.
- R2: A 16-bit sub-counter starts at MS_PER_SEC (default 1000) and drops by one on each accepted tick. When it would reach zero, the seconds count increments and the sub-counter reloads to MS_PER_SEC. With the defaults, the seconds count becomes 1 on the 1000th tick after reset.
- R3: The signed 32-bit sleep-head delay drops by one on an accepted tick only if the sleep-queue-nonempty input is 1 during the ACK cycle. Otherwise it is unchanged.
- R4: When the decremented head delay is zero or negative, wake_o is high for exactly one cycle, the NOTIFY cycle. If no decrement took place, no wakeup is raised.
- R5: The signed 32-bit quantum drops by one on every accepted tick. When the result is zero or negative, resched_o is high for exactly the NOTIFY cycle. This repeats on every later tick until the quantum is reloaded.
- R6: After reset the following hold: millisecond count 0, seconds count 0, head delay 0, quantum QUANTUM (default 10). All pulses and sticky bits are 0.
- R7: eoi_o is high for exactly one cycle, the cycle after the tick is sampled. It is never high in the same cycle as a request pulse, and the counters still hold their old values while it is high.
- R8: A load writes its value at the next edge. If the load comes in the same cycle as the tick, or during ACK, that counter takes the loaded value, skips that tick's decrement and raises no request for it.
- R9: Each sticky bit is set in the cycle after its request pulse and stays set until clear_i is sampled high. If a set and a clear coincide, the set wins.
- R10: A tick strobe that arrives while the block is in ACK or NOTIFY is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Periodic timer tick strobe |
| sleep_nonempty_i | input | 1 | Sleep queue holds at least one entry |
| head_load_i | input | 1 | Load strobe for the sleep-head delay |
| head_val_i | input | 32 | Signed value for the sleep-head delay |
| quant_load_i | input | 1 | Load strobe for the preemption quantum |
| quant_val_i | input | 32 | Signed value for the quantum |
| clear_i | input | 1 | Clears both sticky bits |
| eoi_o | output | 1 | End-of-interrupt acknowledge pulse |
| ms_count_o | output | 32 | Millisecond count |
| sec_count_o | output | 32 | Seconds count |
| head_delay_o | output | 32 | Current signed sleep-head delay |
| quant_o | output | 32 | Current signed quantum |
| wake_o | output | 1 | Wakeup request pulse |
| resched_o | output | 1 | Reschedule request pulse |
| wake_sticky_o | output | 1 | Sticky wakeup status |
| resched_sticky_o | output | 1 | Sticky reschedule status |

## Verification
The quantum is stepped from its reset value down through zero into negative values. This separates a "reaches zero" trigger from a "zero or below" trigger. The head delay is driven with the queue flagged nonempty and flagged empty, and from a negative loaded value. These patterns separate a gated decrement from an ungated one. Loads that coincide with a tick, a tick strobe held through the busy states, and a 1000-tick run across the seconds boundary check the priority and reload rules at their edges.

// File: rtl/tick_assist_pkg.sv
package tick_assist_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACK    = 2'd1,
        ST_NOTIFY = 2'd2
    } tick_state_t;
endpackage

// File: rtl/tick_fsm.sv
module tick_fsm
    import tick_assist_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    output logic accept_o,
    output logic ack_o,
    output logic notify_o
);
    tick_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (tick_i) state_d = ST_ACK;
            ST_ACK:    state_d = ST_NOTIFY;
            ST_NOTIFY: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        accept_o = (state_q == ST_IDLE) && tick_i;
        ack_o    = (state_q == ST_ACK);
        notify_o = (state_q == ST_NOTIFY);
    end
endmodule

// File: rtl/wall_clock.sv
module wall_clock #(
    parameter int CNT_W      = 32,
    parameter int SUB_W      = 16,
    parameter int MS_PER_SEC = 1000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_i,
    output logic [CNT_W-1:0] ms_o,
    output logic [CNT_W-1:0] sec_o
);
    localparam logic [SUB_W-1:0] RELOAD = SUB_W'(MS_PER_SEC);
    localparam logic [SUB_W-1:0] ONE    = SUB_W'(1);

    logic [SUB_W-1:0] sub_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ms_o  <= '0;
            sec_o <= '0;
            sub_q <= RELOAD;
        end else if (step_i) begin
            ms_o <= ms_o + 1'b1;
            if (sub_q == ONE) begin
                sub_q <= RELOAD;
                sec_o <= sec_o + 1'b1;
            end else begin
                sub_q <= sub_q - ONE;
            end
        end
    end
endmodule

// File: rtl/down_counter.sv
module down_counter #(
    parameter int W       = 32,
    parameter int RST_VAL = 0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_i,
    input  logic signed [W-1:0] load_val_i,
    input  logic                step_i,
    output logic signed [W-1:0] count_o,
    output logic                expire_o
);
    logic signed [W-1:0] next_val;
    assign next_val = count_o - W'(1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_o  <= W'(RST_VAL);
            expire_o <= 1'b0;
        end else if (load_i) begin
            count_o  <= load_val_i;
            expire_o <= 1'b0;
        end else if (step_i) begin
            count_o  <= next_val;
            expire_o <= (next_val <= 0);
        end else begin
            expire_o <= 1'b0;
        end
    end
endmodule

// File: rtl/tick_assist.sv
module tick_assist #(
    parameter int CNT_W      = 32,
    parameter int SUB_W      = 16,
    parameter int MS_PER_SEC = 1000,
    parameter int QUANTUM    = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             sleep_nonempty_i,
    input  logic             head_load_i,
    input  logic [CNT_W-1:0] head_val_i,
    input  logic             quant_load_i,
    input  logic [CNT_W-1:0] quant_val_i,
    input  logic             clear_i,
    output logic             eoi_o,
    output logic [CNT_W-1:0] ms_count_o,
    output logic [CNT_W-1:0] sec_count_o,
    output logic [CNT_W-1:0] head_delay_o,
    output logic [CNT_W-1:0] quant_o,
    output logic             wake_o,
    output logic             resched_o,
    output logic             wake_sticky_o,
    output logic             resched_sticky_o
);
    logic accept, ack, notify;
    logic skip_head_q, skip_quant_q;
    logic head_exp, quant_exp;
    logic signed [CNT_W-1:0] head_cnt, quant_cnt;

    tick_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick_i),
        .accept_o (accept),
        .ack_o    (ack),
        .notify_o (notify)
    );

    wall_clock #(
        .CNT_W      (CNT_W),
        .SUB_W      (SUB_W),
        .MS_PER_SEC (MS_PER_SEC)
    ) u_clock (
        .clk    (clk),
        .rst_n  (rst_n),
        .step_i (ack),
        .ms_o   (ms_count_o),
        .sec_o  (sec_count_o)
    );

    // A load that coincides with the tick suppresses that tick's step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            skip_head_q  <= 1'b0;
            skip_quant_q <= 1'b0;
        end else if (accept) begin
            skip_head_q  <= head_load_i;
            skip_quant_q <= quant_load_i;
        end else if (notify) begin
            skip_head_q  <= 1'b0;
            skip_quant_q <= 1'b0;
        end
    end

    down_counter #(.W(CNT_W), .RST_VAL(0)) u_head (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (head_load_i),
        .load_val_i (head_val_i),
        .step_i     (ack && sleep_nonempty_i && !skip_head_q),
        .count_o    (head_cnt),
        .expire_o   (head_exp)
    );

    down_counter #(.W(CNT_W), .RST_VAL(QUANTUM)) u_quant (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (quant_load_i),
        .load_val_i (quant_val_i),
        .step_i     (ack && !skip_quant_q),
        .count_o    (quant_cnt),
        .expire_o   (quant_exp)
    );

    always_comb begin
        eoi_o        = ack;
        wake_o       = notify && head_exp;
        resched_o    = notify && quant_exp;
        head_delay_o = head_cnt;
        quant_o      = quant_cnt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wake_sticky_o    <= 1'b0;
            resched_sticky_o <= 1'b0;
        end else begin
            wake_sticky_o    <= wake_o    || (wake_sticky_o    && !clear_i);
            resched_sticky_o <= resched_o || (resched_sticky_o && !clear_i);
        end
    end
endmodule

// File: rtl/tick_assist_chk.sv
module tick_assist_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             eoi_o,
    input logic             wake_o,
    input logic             resched_o,
    input logic             wake_sticky_o,
    input logic             resched_sticky_o,
    input logic [CNT_W-1:0] ms_count_o,
    input logic [CNT_W-1:0] sec_count_o,
    input logic [CNT_W-1:0] head_delay_o,
    input logic [CNT_W-1:0] quant_o
);
    assert_ms_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_o |=> ms_count_o == $past(ms_count_o) + 1'b1);

    assert_ms_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !eoi_o |=> $stable(ms_count_o));

    assert_sec_only_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !eoi_o |=> $stable(sec_count_o));

    assert_wake_nonpos_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> $signed(head_delay_o) <= 0);

    assert_wake_after_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> $past(eoi_o));

    assert_resched_nonpos_R5: assert property (@(posedge clk) disable iff (!rst_n)
        resched_o |-> $signed(quant_o) <= 0);

    assert_eoi_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_o |=> !eoi_o);

    assert_eoi_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({eoi_o, wake_o}) && $onehot0({eoi_o, resched_o}));

    assert_wake_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |=> wake_sticky_o);

    assert_resched_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        resched_o |=> resched_sticky_o);
endmodule

bind tick_assist tick_assist_chk #(.CNT_W(CNT_W)) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .eoi_o            (eoi_o),
    .wake_o           (wake_o),
    .resched_o        (resched_o),
    .wake_sticky_o    (wake_sticky_o),
    .resched_sticky_o (resched_sticky_o),
    .ms_count_o       (ms_count_o),
    .sec_count_o      (sec_count_o),
    .head_delay_o     (head_delay_o),
    .quant_o          (quant_o)
);

// File: tb/tick_assist_bench.sv
`timescale 1ns/1ps
module tick_assist_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_i = 1'b0;
    logic        sleep_nonempty_i = 1'b0;
    logic        head_load_i = 1'b0;
    logic [31:0] head_val_i = '0;
    logic        quant_load_i = 1'b0;
    logic [31:0] quant_val_i = '0;
    logic        clear_i = 1'b0;
    logic        eoi_o, wake_o, resched_o, wake_sticky_o, resched_sticky_o;
    logic [31:0] ms_count_o, sec_count_o, head_delay_o, quant_o;

    int n_chk = 0;
    int n_bad = 0;
    int exp_ms = 0;
    bit done = 1'b0;

    // Results seen during the last tick
    logic seen_eoi, seen_eoi_late, seen_wake, seen_resched;

    always #2.5 clk = ~clk;

    tick_assist u_tick_assist (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
        .sleep_nonempty_i(sleep_nonempty_i),
        .head_load_i(head_load_i), .head_val_i(head_val_i),
        .quant_load_i(quant_load_i), .quant_val_i(quant_val_i),
        .clear_i(clear_i), .eoi_o(eoi_o),
        .ms_count_o(ms_count_o), .sec_count_o(sec_count_o),
        .head_delay_o(head_delay_o), .quant_o(quant_o),
        .wake_o(wake_o), .resched_o(resched_o),
        .wake_sticky_o(wake_sticky_o), .resched_sticky_o(resched_sticky_o)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what,
                     $signed(act), $signed(exp));
        end
    endtask

    // One tick; optional same-cycle loads. Ends with the FSM back in IDLE.
    task automatic do_tick(input logic ld_h, input logic [31:0] hv,
                           input logic ld_q, input logic [31:0] qv);
        @(negedge clk);
        tick_i = 1'b1; head_load_i = ld_h; head_val_i = hv;
        quant_load_i = ld_q; quant_val_i = qv;
        @(negedge clk);
        tick_i = 1'b0; head_load_i = 1'b0; quant_load_i = 1'b0;
        seen_eoi = eoi_o;
        @(negedge clk);
        seen_wake = wake_o; seen_resched = resched_o; seen_eoi_late = eoi_o;
        exp_ms++;
        @(negedge clk);
    endtask

    task automatic plain_tick();
        do_tick(1'b0, '0, 1'b0, '0);
    endtask

    task automatic test_reset();
        chk("R6", "ms", ms_count_o, 0);
        chk("R6", "sec", sec_count_o, 0);
        chk("R6", "head", head_delay_o, 0);
        chk("R6", "quant", quant_o, 10);
        chk("R6", "pulses", {wake_o, resched_o, eoi_o}, 0);
        chk("R6", "sticky", {wake_sticky_o, resched_sticky_o}, 0);
    endtask

    task automatic test_basic();
        logic [31:0] ms_before;
        sleep_nonempty_i = 1'b0;
        @(negedge clk);
        tick_i = 1'b1;
        @(negedge clk);
        tick_i = 1'b0;
        chk("R7", "eoi in ack", eoi_o, 1);
        ms_before = ms_count_o;
        chk("R7", "ms unchanged during eoi", ms_before, 0);
        @(negedge clk);
        chk("R7", "eoi one cycle", eoi_o, 0);
        chk("R1", "ms after tick", ms_count_o, 1);
        chk("R5", "quant after 1 tick", quant_o, 9);
        chk("R3", "head untouched, queue empty", head_delay_o, 0);
        chk("R4", "no wake, queue empty", wake_o, 0);
        exp_ms++;
        @(negedge clk);
    endtask

    task automatic test_quantum();
        for (int i = 2; i <= 9; i++) begin
            plain_tick();
            chk("R5", "no early resched", seen_resched, 0);
        end
        chk("R5", "quant at 1", quant_o, 1);
        plain_tick();
        chk("R5", "resched at zero", seen_resched, 1);
        chk("R5", "quant zero", quant_o, 0);
        chk("R7", "eoi not with resched", seen_eoi_late, 0);
        plain_tick();
        chk("R5", "resched below zero", seen_resched, 1);
        chk("R5", "quant -1", quant_o, 32'hFFFF_FFFF);
        chk("R1", "ms count", ms_count_o, exp_ms);
    endtask

    task automatic test_sticky();
        chk("R9", "resched sticky set", resched_sticky_o, 1);
        chk("R9", "wake sticky still 0", wake_sticky_o, 0);
        @(negedge clk) clear_i = 1'b1;
        @(negedge clk) clear_i = 1'b0;
        chk("R9", "resched sticky cleared", resched_sticky_o, 0);
        @(negedge clk) quant_load_i = 1'b1; quant_val_i = 32'd100;
        @(negedge clk) quant_load_i = 1'b0;
        chk("R8", "quant reload", quant_o, 100);
    endtask

    task automatic test_sleep();
        @(negedge clk) head_load_i = 1'b1; head_val_i = 32'd3;
        @(negedge clk) head_load_i = 1'b0;
        sleep_nonempty_i = 1'b1;
        plain_tick();
        chk("R3", "head 2", head_delay_o, 2);
        chk("R4", "no wake at 2", seen_wake, 0);
        plain_tick();
        chk("R4", "no wake at 1", seen_wake, 0);
        plain_tick();
        chk("R4", "wake at zero", seen_wake, 1);
        chk("R3", "head 0", head_delay_o, 0);
        chk("R9", "wake sticky set", wake_sticky_o, 1);
        sleep_nonempty_i = 1'b0;
        plain_tick();
        chk("R3", "head held when empty", head_delay_o, 0);
        chk("R4", "no wake when empty", seen_wake, 0);
        sleep_nonempty_i = 1'b1;
        @(negedge clk) head_load_i = 1'b1; head_val_i = -32'sd5;
        @(negedge clk) head_load_i = 1'b0;
        plain_tick();
        chk("R4", "wake from negative", seen_wake, 1);
        chk("R3", "head -6", head_delay_o, -32'sd6);
    endtask

    task automatic test_load_priority();
        sleep_nonempty_i = 1'b1;
        do_tick(1'b1, 32'd7, 1'b1, 32'd1);
        chk("R8", "head load wins", head_delay_o, 7);
        chk("R8", "quant load wins", quant_o, 1);
        chk("R8", "no wake on load", seen_wake, 0);
        chk("R8", "no resched on load", seen_resched, 0);
        chk("R8", "eoi still sent", seen_eoi, 1);
        chk("R1", "ms still counted", ms_count_o, exp_ms);
        plain_tick();
        chk("R5", "resched after load", seen_resched, 1);
        chk("R3", "head 6", head_delay_o, 6);
    endtask

    task automatic test_busy();
        @(negedge clk) tick_i = 1'b1;
        @(negedge clk);
        @(negedge clk);
        @(negedge clk) tick_i = 1'b0;
        @(negedge clk);
        exp_ms++;
        chk("R10", "held tick counted once", ms_count_o, exp_ms);
    endtask

    task automatic test_seconds();
        sleep_nonempty_i = 1'b0;
        while (exp_ms < 999) plain_tick();
        chk("R2", "sec before boundary", sec_count_o, 0);
        plain_tick();
        chk("R2", "sec at 1000 ticks", sec_count_o, 1);
        chk("R1", "ms at 1000", ms_count_o, 1000);
        plain_tick();
        chk("R2", "sec stays 1", sec_count_o, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_basic();
        test_quantum();
        test_sticky();
        test_sleep();
        test_load_priority();
        test_busy();
        test_seconds();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule